// File: doc/BRIEF.md
# Network media port selector

This block decides which of two physical media interfaces is in use: an attachment-unit port or a twisted-pair port. The choice comes from one of three sources, picked by a two-bit mode code held in a small control register. The sources are a two-bit software port field, an external jumper pin, and an automatic choice that follows the twisted-pair receiver's link-good indication. The fourth mode code is reserved. While that code is programmed, the block keeps its previous choice and raises an error flag.

The same control register holds a wake-enable bit and an address-match-mode enable bit. During sleep the block drives a keep-alive signal that leaves the twisted-pair receiver listening for link pulses. It does so only when wake is enabled, the link is good and the twisted-pair port is the selected one. The address-match-mode enable reaches its output only while the pin-select mode bit is clear.

A plain single-cycle register port writes the control register and the software port field and reads them back. The jumper pin and the link-good input are asynchronous, and each passes through a two-flop synchroniser before any use.

Top module: `media_port_sel`

## Requirements
- R1: After reset the control register reads 0x02: the auto bit is set and every other bit is clear. The software port field reads 0. `port_sel` is 2'b01 (attachment unit) and `mode_err` is 0.
- R2: Mode code 00 (auto bit 0, pin bit 0) selects from the software port field. Field value 2'b01 selects twisted pair and every other value selects the attachment unit. `port_sel` follows one clock after the register write.
- R3: Mode code 01 selects from the jumper pin, with high meaning twisted pair. A pin change reaches `port_sel` on the third rising edge after it.
- R4: Mode code 10 selects twisted pair while link-good is high and the attachment unit otherwise. A change of link-good reaches `port_sel` on the third rising edge after it.
- R5: Under mode code 11, `port_sel` holds its previous value and `mode_err` is 1, one clock after the code is written. Leaving that code clears `mode_err` one clock later.
- R6: `port_sel` always has exactly one bit set. Bit 0 is the attachment unit and bit 1 is twisted pair.
- R7: `rx_keep_alive` is high exactly when `sleep_req` is high, the wake bit is set, the synchronised link-good is high and twisted pair is selected.
- R8: `match_mode_en` equals the match-enable bit while the pin bit is 0, and is 0 while the pin bit is 1.
- R9: Reads are combinational. Address 0 returns the control bits: bit 0 is the pin bit, bit 1 the auto bit, bit 2 the wake bit and bit 3 the match-enable bit. Address 1 returns the software port field in bits 1:0. All other bits read 0, and written values in unused bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 is control, 1 is the software port field |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| jumper_pin | input | 1 | External port jumper, asynchronous; high means twisted pair |
| link_good | input | 1 | Twisted-pair link indication, asynchronous |
| sleep_req | input | 1 | Sleep state request |
| port_sel | output | 2 | One-hot active port: bit 0 is the attachment unit, bit 1 is twisted pair |
| rx_keep_alive | output | 1 | Keep the twisted-pair receiver active during sleep |
| match_mode_en | output | 1 | Effective address-match-mode enable |
| mode_err | output | 1 | The reserved mode code is programmed |

## Verification
Each result is due at a fixed number of clock edges after its stimulus. A register write moves `port_sel` and `mode_err` one edge after the write edge. A change on the jumper pin or on link-good moves `port_sel` on the third edge. `reg_rdata` and `match_mode_en` are combinational from the registers, so they are valid right after the write edge. `rx_keep_alive` follows `sleep_req` at once. The bench drives every input on a falling edge and counts falling edges to the exact edge where each result is due before it samples. The reserved-mode test changes link-good after the write and waits more than the sync latency, which shows that `port_sel` is held rather than merely slow.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [1:0] {
    MODE_SW   = 2'b00,
    MODE_PIN  = 2'b01,
    MODE_AUTO = 2'b10,
    MODE_RSVD = 2'b11
  } mode_e;

  localparam int PORT_W = 2;
  localparam logic [PORT_W-1:0] SEL_AUI = 2'b01;
  localparam logic [PORT_W-1:0] SEL_TP  = 2'b10;

  localparam int SWP_W = 2;
  localparam logic [SWP_W-1:0] SWP_TP_CODE = 2'b01;

  localparam int CTRL_BITS = 4;
  localparam logic [CTRL_BITS-1:0] CTRL_RESET = 4'b0010;
endpackage

// File: rtl/mps_sync.sv
module mps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mps_ctrl_reg.sv
module mps_ctrl_reg
  import mps_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pin_bit,
  output logic              auto_bit,
  output logic              wake_bit,
  output logic              match_bit,
  output logic [SWP_W-1:0]  sw_port
);
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_SWP  = ADDR_W'(1);

  logic [CTRL_BITS-1:0] ctrl_q;
  logic [SWP_W-1:0]     swp_q;
  logic                 unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:CTRL_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      swp_q  <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl_q <= wdata[CTRL_BITS-1:0];
      if (addr == A_SWP)  swp_q  <= wdata[SWP_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)     rdata[CTRL_BITS-1:0] = ctrl_q;
    else if (addr == A_SWP) rdata[SWP_W-1:0]     = swp_q;
  end

  assign pin_bit   = ctrl_q[0];
  assign auto_bit  = ctrl_q[1];
  assign wake_bit  = ctrl_q[2];
  assign match_bit = ctrl_q[3];
  assign sw_port   = swp_q;

  // R9: a write to control lands on the next edge
  assert_ctrl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> ({match_bit, wake_bit, auto_bit, pin_bit} == $past(wdata[CTRL_BITS-1:0])));
  // R9: unused read bits are zero
  assert_rdata_hi_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:CTRL_BITS] == '0);
endmodule

// File: rtl/mps_port_pick.sv
module mps_port_pick
  import mps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_bit,
  input  logic              auto_bit,
  input  logic [SWP_W-1:0]  sw_port,
  input  logic              jumper_s,
  input  logic              link_s,
  output logic [PORT_W-1:0] port_sel,
  output logic              mode_err
);
  mode_e             mode;
  logic [PORT_W-1:0] sel_d;

  assign mode = mode_e'({auto_bit, pin_bit});

  always_comb begin
    unique case (mode)
      MODE_SW:   sel_d = (sw_port == SWP_TP_CODE) ? SEL_TP : SEL_AUI;
      MODE_PIN:  sel_d = jumper_s ? SEL_TP : SEL_AUI;
      MODE_AUTO: sel_d = link_s ? SEL_TP : SEL_AUI;
      default:   sel_d = port_sel;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_sel <= SEL_AUI;
      mode_err <= 1'b0;
    end else begin
      port_sel <= sel_d;
      mode_err <= (mode == MODE_RSVD);
    end
  end

  assert_onehot_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_sel) == 1);
  assert_rsvd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RSVD) |=> $stable(port_sel));
  assert_rsvd_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RSVD) |=> mode_err);
  assert_auto_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_AUTO && link_s) |=> (port_sel == SEL_TP));
  assert_pin_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PIN && !jumper_s) |=> (port_sel == SEL_AUI));
endmodule

// File: rtl/media_port_sel.sv
module media_port_sel
  import mps_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              jumper_pin,
  input  logic              link_good,
  input  logic              sleep_req,
  output logic [1:0]        port_sel,
  output logic              rx_keep_alive,
  output logic              match_mode_en,
  output logic              mode_err
);
  logic             pin_bit, auto_bit, wake_bit, match_bit;
  logic [SWP_W-1:0] sw_port;
  logic             jumper_s, link_s;

  mps_ctrl_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .pin_bit(pin_bit),
    .auto_bit(auto_bit), .wake_bit(wake_bit), .match_bit(match_bit),
    .sw_port(sw_port)
  );

  mps_sync #(.STAGES(SYNC_STAGES)) u_sync_jumper (
    .clk(clk), .rst_n(rst_n), .d_async(jumper_pin), .q_sync(jumper_s)
  );

  mps_sync #(.STAGES(SYNC_STAGES)) u_sync_link (
    .clk(clk), .rst_n(rst_n), .d_async(link_good), .q_sync(link_s)
  );

  mps_port_pick u_pick (
    .clk(clk), .rst_n(rst_n), .pin_bit(pin_bit), .auto_bit(auto_bit),
    .sw_port(sw_port), .jumper_s(jumper_s), .link_s(link_s),
    .port_sel(port_sel), .mode_err(mode_err)
  );

  assign rx_keep_alive = sleep_req && wake_bit && link_s && (port_sel == SEL_TP);
  assign match_mode_en = match_bit && !pin_bit;

  assert_keep_alive_tp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_keep_alive |-> (port_sel == SEL_TP && sleep_req));
  assert_match_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_mode_en |-> (reg_addr != '0 || reg_rdata[0] == 1'b0));
endmodule

// File: tb/media_port_sel_bench.sv
`timescale 1ns/1ps
module media_port_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_wr_en = 0;
  logic [0:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       jumper_pin = 0, link_good = 0, sleep_req = 0;
  logic [1:0] port_sel;
  logic       rx_keep_alive, match_mode_en, mode_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  media_port_sel u_media_port_sel (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .jumper_pin(jumper_pin),
    .link_good(link_good), .sleep_req(sleep_req), .port_sel(port_sel),
    .rx_keep_alive(rx_keep_alive), .match_mode_en(match_mode_en),
    .mode_err(mode_err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); check("R1 ctrl reset", d, 8'h02);
    rd(1, d); check("R1 swp reset", d, 8'h00);
    check("R1 port_sel reset", {6'b0, port_sel}, 8'h01);
    check("R1 mode_err reset", {7'b0, mode_err}, 8'h00);
  endtask

  task automatic t_sw_mode;
    wr(1, 8'h01);
    wr(0, 8'h00);
    tick(1); check("R2 sw 01 -> tp", {6'b0, port_sel}, 8'h02);
    check("R6 onehot", {7'b0, port_sel[0] ^ port_sel[1]}, 8'h01);
    wr(1, 8'h03);
    tick(1); check("R2 sw 11 -> aui", {6'b0, port_sel}, 8'h01);
    wr(1, 8'h01);
    tick(1); check("R2 sw 01 again", {6'b0, port_sel}, 8'h02);
    wr(1, 8'h00);
    tick(1); check("R2 sw 00 -> aui", {6'b0, port_sel}, 8'h01);
  endtask

  task automatic t_pin_mode;
    wr(0, 8'h01);
    jumper_pin = 1;
    tick(2); check("R3 pin not yet", {6'b0, port_sel}, 8'h01);
    tick(1); check("R3 pin high -> tp", {6'b0, port_sel}, 8'h02);
    jumper_pin = 0;
    tick(3); check("R3 pin low -> aui", {6'b0, port_sel}, 8'h01);
  endtask

  task automatic t_auto_mode;
    wr(0, 8'h02);
    link_good = 1;
    tick(2); check("R4 link not yet", {6'b0, port_sel}, 8'h01);
    tick(1); check("R4 link up -> tp", {6'b0, port_sel}, 8'h02);
    link_good = 0;
    tick(3); check("R4 link down -> aui", {6'b0, port_sel}, 8'h01);
    link_good = 1;
    tick(3); check("R4 link up again", {6'b0, port_sel}, 8'h02);
  endtask

  task automatic t_reserved;
    wr(0, 8'h03);
    tick(1); check("R5 err set", {7'b0, mode_err}, 8'h01);
    link_good = 0;
    tick(5); check("R5 hold tp", {6'b0, port_sel}, 8'h02);
    wr(1, 8'h00);
    wr(0, 8'h00);
    tick(1); check("R5 err cleared", {7'b0, mode_err}, 8'h00);
    check("R5 leave -> sw aui", {6'b0, port_sel}, 8'h01);
  endtask

  task automatic t_keep_alive;
    wr(0, 8'h06);
    link_good = 1; sleep_req = 1;
    tick(3); check("R7 keep alive on", {7'b0, rx_keep_alive}, 8'h01);
    sleep_req = 0; #1;
    check("R7 no sleep", {7'b0, rx_keep_alive}, 8'h00);
    sleep_req = 1;
    wr(0, 8'h02); #1;
    check("R7 wake off", {7'b0, rx_keep_alive}, 8'h00);
    wr(0, 8'h04);
    wr(1, 8'h00);
    tick(1); check("R7 aui selected", {7'b0, rx_keep_alive}, 8'h00);
    sleep_req = 0; link_good = 0;
  endtask

  task automatic t_match;
    wr(0, 8'h08); #1;
    check("R8 match on", {7'b0, match_mode_en}, 8'h01);
    wr(0, 8'h09); #1;
    check("R8 match gated by pin", {7'b0, match_mode_en}, 8'h00);
    wr(0, 8'h00); #1;
    check("R8 match off", {7'b0, match_mode_en}, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr(0, 8'hFD);
    rd(0, d); check("R9 ctrl readback", d, 8'h0D);
    wr(1, 8'hF2);
    rd(1, d); check("R9 swp readback", d, 8'h02);
    wr(0, 8'h02);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_sw_mode();
    t_pin_mode();
    t_auto_mode();
    t_reserved();
    t_keep_alive();
    t_match();
    t_readback();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule